// File: doc/BRIEF.md
# System Reset Sequencer

This block decides when each part of a small controller system is held in reset. It watches four request sources: a power-on reset, a shared active-low reset line that other devices may pull, a request from the internal system module, and a one-cycle strobe raised when software executes a "reset peripherals" operation. It pulls the shared line low through an output enable (open-drain style) and senses the level of the line on a separate input.

Each source selects its own set of reset domains: the CPU core, the on-chip peripheral modules, the peripherals' configuration registers, and the shared line. A software strobe resets the peripherals and the external devices but leaves the core and the configuration registers running. Every request reloads a common stretch counter, so every reset lasts at least a guaranteed number of cycles. All outputs are released together once the counter has run out and no source is active. A one-hot cause register records which source started the most recent reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, all three domain resets are low, `line_oe` is 1 and `cause` is 4'b0001. After `por_n` rises, all outputs stay asserted for exactly STRETCH_CYCLES clock edges.
- R2: Each time the block drives the shared line, `line_oe` stays high for at least STRETCH_CYCLES cycles. A single request gives exactly STRETCH_CYCLES cycles.
- R3: A `sys_req` cycle asserts `core_rst_n`, `periph_rst_n` and `cfg_rst_n` low and raises `line_oe` on the next clock edge.
- R4: A `sw_req` strobe raises `line_oe` and pulls `periph_rst_n` low. `core_rst_n` and `cfg_rst_n` are left unchanged.
- R5: A low level on `line_in` that the block did not cause passes through a SYNC_STAGES-flop synchroniser. It then resets core, peripherals and configuration without the block driving `line_oe`. The outputs release STRETCH_CYCLES+SYNC_STAGES edges after the line returns high.
- R6: When the block releases the line, its own drive, still in the synchroniser, never starts an external reset.
- R7: A new request during a reset reloads the count, so the outputs release STRETCH_CYCLES edges after the last request.
- R8: All asserted outputs are released on the same clock edge.
- R9: `cause` is one-hot: bit0 power-on, bit1 external line, bit2 system module, bit3 software. Simultaneous requests record the first of external, system, software. Only power-on resets the register to bit0.
- R10: Domains requested by different sources during one reset are combined. A system request that arrives during a software reset also resets the core and configuration.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| line_in | input | 1 | Sensed level of the shared reset line (low = reset) |
| sys_req | input | 1 | Reset request from the internal system module, active high |
| sw_req | input | 1 | One-cycle strobe from the software reset operation |
| line_oe | output | 1 | 1 = pull the shared line low |
| core_rst_n | output | 1 | CPU core reset, active low |
| periph_rst_n | output | 1 | On-chip peripheral reset, active low |
| cfg_rst_n | output | 1 | Peripheral configuration register reset, active low |
| cause | output | 4 | One-hot cause of the most recent reset |

## Verification
The hardest point to reach is the edge where the block lets go of the line. The synchroniser still shows the low level the block drove itself, and a correct design must not mistake it for an external reset. Every release of an internally driven reset goes through that window. After the release, the bench checks that the outputs stay deasserted and that `cause` keeps its value. It also stretches a reset with a second request partway through, and mixes a software strobe with a later system request. Together these exercise both the counter reload and the combining of domains.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int DOM_CORE   = 0;
   localparam int DOM_PERIPH = 1;
   localparam int DOM_CFG    = 2;
   localparam int DOM_LINE   = 3;
   localparam int NUM_DOM    = 4;

   typedef logic [NUM_DOM-1:0] dom_mask_t;

   // domain sets per source: {line, cfg, periph, core}
   localparam dom_mask_t MASK_POR = 4'b1111;
   localparam dom_mask_t MASK_EXT = 4'b0111;
   localparam dom_mask_t MASK_SYS = 4'b1111;
   localparam dom_mask_t MASK_SW  = 4'b1010;

   typedef logic [3:0] cause_t;
   localparam cause_t CAUSE_POR = 4'b0001;
   localparam cause_t CAUSE_EXT = 4'b0010;
   localparam cause_t CAUSE_SYS = 4'b0100;
   localparam cause_t CAUSE_SW  = 4'b1000;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d,
   output logic [STAGES-1:0] taps
);
   initial begin
      if (STAGES < 1) $error("rstseq_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps <= RST_VAL;
            else        taps <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps <= {STAGES{RST_VAL}};
            else        taps <= {taps[STAGES-2:0], d};
         end
      end
   endgenerate
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
   parameter int CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic busy,
   output logic expired
);
   localparam int            CW   = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      if (CYCLES < 2) $error("rstseq_stretch: CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= LOAD;
      else if (restart)                cnt_q <= LOAD;
      else if (busy && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int STRETCH_CYCLES = 512,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       line_in,
   input  logic       sys_req,
   input  logic       sw_req,
   output logic       line_oe,
   output logic       core_rst_n,
   output logic       periph_rst_n,
   output logic       cfg_rst_n,
   output logic [3:0] cause
);
   initial begin
      if (STRETCH_CYCLES < 2) $error("rstseq_ctrl: STRETCH_CYCLES must be at least 2");
      if (SYNC_STAGES < 2)    $error("rstseq_ctrl: SYNC_STAGES must be at least 2");
   end

   dom_mask_t              mask_q;
   dom_mask_t              req_mask;
   cause_t                 cause_q;
   logic [SYNC_STAGES-1:0] line_taps;
   logic [SYNC_STAGES-1:0] oe_taps;
   logic                   ext_act;
   logic                   req_any;
   logic                   expired;

   // shared line brought into the clock domain
   rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (line_in),
      .taps  (line_taps)
   );

   // recent history of own drive, aligned with the synchroniser delay
   rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_oe_hist (
      .clk   (clk),
      .rst_n (por_n),
      .d     (mask_q[DOM_LINE]),
      .taps  (oe_taps)
   );

   assign ext_act = ~line_taps[SYNC_STAGES-1] & ~mask_q[DOM_LINE] & ~(|oe_taps);
   assign req_any = ext_act | sys_req | sw_req;

   always_comb begin
      req_mask = '0;
      if (ext_act) req_mask = req_mask | MASK_EXT;
      if (sys_req) req_mask = req_mask | MASK_SYS;
      if (sw_req)  req_mask = req_mask | MASK_SW;
   end

   rstseq_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
      .clk     (clk),
      .rst_n   (por_n),
      .restart (req_any),
      .busy    (|mask_q),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mask_q  <= MASK_POR;
         cause_q <= CAUSE_POR;
      end else if (req_any) begin
         mask_q <= mask_q | req_mask;
         if (ext_act)      cause_q <= CAUSE_EXT;
         else if (sys_req) cause_q <= CAUSE_SYS;
         else              cause_q <= CAUSE_SW;
      end else if (expired) begin
         mask_q <= '0;
      end
   end

   assign line_oe      = mask_q[DOM_LINE];
   assign core_rst_n   = ~mask_q[DOM_CORE];
   assign periph_rst_n = ~mask_q[DOM_PERIPH];
   assign cfg_rst_n    = ~mask_q[DOM_CFG];
   assign cause        = cause_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int STRETCH_CYCLES = 512
) (
   input logic       clk,
   input logic       por_n,
   input logic       sys_req,
   input logic       ext_act,
   input logic       line_oe,
   input logic       core_rst_n,
   input logic       periph_rst_n,
   input logic       cfg_rst_n,
   input logic [3:0] cause
);
   int unsigned drive_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                drive_run <= 0;
      else if (!line_oe)         drive_run <= 0;
      else if (drive_run < 32'hFFFF_FFF0) drive_run <= drive_run + 1;
   end

   assert_min_width_R2: assert property (@(posedge clk) disable iff (!por_n)
      $fell(line_oe) |-> drive_run >= STRETCH_CYCLES);

   assert_sys_all_R3: assert property (@(posedge clk) disable iff (!por_n)
      sys_req |=> (!core_rst_n && !periph_rst_n && !cfg_rst_n && line_oe));

   assert_core_kept_R4: assert property (@(posedge clk) disable iff (!por_n)
      (core_rst_n && !sys_req && !ext_act) |=> core_rst_n);

   assert_cfg_kept_R4: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_rst_n && !sys_req && !ext_act) |=> cfg_rst_n);

   assert_joint_release_R8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(periph_rst_n) |-> (core_rst_n && cfg_rst_n && !line_oe));

   assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!por_n)
      $countones(cause) == 1);
endmodule

bind rstseq_ctrl rstseq_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_rstseq_chk (
   .clk          (clk),
   .por_n        (por_n),
   .sys_req      (sys_req),
   .ext_act      (ext_act),
   .line_oe      (line_oe),
   .core_rst_n   (core_rst_n),
   .periph_rst_n (periph_rst_n),
   .cfg_rst_n    (cfg_rst_n),
   .cause        (cause)
);

// File: tb/test_rstseq_ctrl.sv
module test_rstseq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int STRETCH    = 512;
   localparam int SYNC       = 2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_req = 1'b0;
   logic       sw_req = 1'b0;
   logic       ext_drv = 1'b0;
   logic       line_in;
   logic       line_oe, core_rst_n, periph_rst_n, cfg_rst_n;
   logic [3:0] cause;

   int    n_tests = 0;
   int    n_fail  = 0;
   string phase   = "R1";
   bit    started = 1'b0;

   assign line_in = ~(line_oe | ext_drv);

   always #(CLK_PERIOD/2) clk = ~clk;

   rstseq_ctrl #(.STRETCH_CYCLES(STRETCH), .SYNC_STAGES(SYNC)) i_rstseq_ctrl (
      .clk(clk), .por_n(por_n), .line_in(line_in), .sys_req(sys_req), .sw_req(sw_req),
      .line_oe(line_oe), .core_rst_n(core_rst_n), .periph_rst_n(periph_rst_n),
      .cfg_rst_n(cfg_rst_n), .cause(cause)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural reference: domain flags, remaining hold time, line and drive history
   bit     m_core = 1, m_per = 1, m_cfg = 1, m_line = 1;
   int     m_left = STRETCH - 1;
   bit [3:0] m_cause = 4'b0001;
   bit     line_hist[$] = '{1'b1, 1'b1};
   bit     drive_hist[$] = '{1'b1, 1'b1};
   bit     m_ext, m_blank, m_any, now_line;

   always @(posedge clk) begin
      if (!por_n) begin
         m_core = 1; m_per = 1; m_cfg = 1; m_line = 1;
         m_left = STRETCH - 1;
         m_cause = 4'b0001;
         line_hist = '{1'b1, 1'b1};
         drive_hist = '{1'b1, 1'b1};
      end else begin
         now_line = !(m_line || ext_drv);
         m_blank = m_line;
         foreach (drive_hist[i]) m_blank = m_blank | drive_hist[i];
         m_ext = !line_hist[SYNC-1] && !m_blank;
         m_any = m_ext || sys_req || sw_req;
         line_hist.push_front(now_line);
         void'(line_hist.pop_back());
         drive_hist.push_front(m_line);
         void'(drive_hist.pop_back());
         if (m_any) begin
            m_left = STRETCH - 1;
            if (m_ext)   begin m_core = 1; m_per = 1; m_cfg = 1; end
            if (sys_req) begin m_core = 1; m_per = 1; m_cfg = 1; m_line = 1; end
            if (sw_req)  begin m_per = 1; m_line = 1; end
            if (m_ext)        m_cause = 4'b0010;
            else if (sys_req) m_cause = 4'b0100;
            else              m_cause = 4'b1000;
         end else if (m_core || m_per || m_cfg || m_line) begin
            if (m_left == 0) begin m_core = 0; m_per = 0; m_cfg = 0; m_line = 0; end
            else m_left--;
         end
      end
   end

   always @(negedge clk) begin
      if (started)
         chk(phase, {24'd0, cause, line_oe, ~cfg_rst_n, ~periph_rst_n, ~core_rst_n},
             {24'd0, m_cause, m_line, m_cfg, m_per, m_core}, "outputs vs model");
   end

   task automatic wait_idle();
      while (line_oe || !periph_rst_n || !core_rst_n) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int n;
      bit seen_core, seen_cfg, seen_per;
      repeat (3) @(negedge clk);
      chk("R1", line_oe, 1, "line driven during power-on");
      chk("R1", {core_rst_n, periph_rst_n, cfg_rst_n}, 3'b000, "domains during power-on");
      chk("R1", cause, 4'b0001, "cause during power-on");
      por_n = 1'b1;
      started = 1'b1;
      n = 0;
      while (!periph_rst_n) begin @(negedge clk); n++; end
      chk("R1", n, STRETCH, "cycles from power-on release");
      wait_idle();

      phase = "R3";
      sys_req = 1'b1; @(negedge clk); sys_req = 1'b0;
      n = 0; seen_core = 0;
      while (line_oe) begin n++; if (core_rst_n || cfg_rst_n) seen_core = 1; @(negedge clk); end
      chk("R2", n, STRETCH, "line width after system request");
      chk("R3", seen_core, 0, "core/cfg held during system reset");
      chk("R9", cause, 4'b0100, "cause after system request");
      wait_idle();

      phase = "R4";
      sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
      n = 0; seen_core = 0; seen_cfg = 0; seen_per = 1;
      while (line_oe) begin
         n++;
         if (!core_rst_n) seen_core = 1;
         if (!cfg_rst_n)  seen_cfg = 1;
         if (periph_rst_n) seen_per = 0;
         @(negedge clk);
      end
      chk("R2", n, STRETCH, "line width after software strobe");
      chk("R4", {seen_core, seen_cfg}, 2'b00, "core/cfg untouched by software strobe");
      chk("R4", seen_per, 1, "peripherals held by software strobe");
      chk("R9", cause, 4'b1000, "cause after software strobe");

      phase = "R6";
      repeat (20) @(negedge clk);
      chk("R6", {core_rst_n, periph_rst_n, cfg_rst_n, line_oe}, 4'b1110, "no reset from own released drive");
      chk("R6", cause, 4'b1000, "cause kept after own release");

      phase = "R5";
      ext_drv = 1'b1;
      repeat (20) @(negedge clk);
      chk("R5", {core_rst_n, periph_rst_n, cfg_rst_n}, 3'b000, "domains under external line");
      chk("R5", line_oe, 0, "block does not drive for external reset");
      chk("R9", cause, 4'b0010, "cause after external line");
      ext_drv = 1'b0;
      n = 0;
      while (!periph_rst_n) begin @(negedge clk); n++; end
      chk("R5", n, STRETCH + SYNC, "release after external line returns high");
      chk("R8", {core_rst_n, cfg_rst_n}, 2'b11, "joint release after external");
      wait_idle();

      phase = "R7";
      sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
      repeat (299) @(negedge clk);
      sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
      n = 300;
      while (line_oe) begin n++; @(negedge clk); end
      chk("R7", n, 300 + STRETCH, "width with restarted count");
      wait_idle();

      phase = "R10";
      sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
      repeat (100) @(negedge clk);
      chk("R4", core_rst_n, 1, "core running before system request");
      sys_req = 1'b1; @(negedge clk); sys_req = 1'b0;
      chk("R10", {core_rst_n, cfg_rst_n, periph_rst_n}, 3'b000, "domains combined");
      while (periph_rst_n == 1'b0) begin
         if (core_rst_n != periph_rst_n || cfg_rst_n != periph_rst_n)
            chk("R8", 1, 0, "domains released apart");
         @(negedge clk);
      end
      chk("R8", {core_rst_n, cfg_rst_n, line_oe}, 3'b110, "all released on one edge");
      wait_idle();

      phase = "R9";
      sys_req = 1'b1; sw_req = 1'b1; @(negedge clk); sys_req = 1'b0; sw_req = 1'b0;
      chk("R9", cause, 4'b0100, "system wins over software");
      chk("R9", core_rst_n, 0, "core reset by simultaneous system request");
      wait_idle();

      started = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule